// File: doc/BRIEF.md
# Multi-Pin Wakeup Event Controller

This block watches eight external wakeup lines that have already been synchronized to the system clock. Each line has its own arm bit, its own edge-sense bit and its own two-bit pad pull code. When an armed line sees an edge in the chosen direction, the block latches a sticky event flag for that line. The block also latches a flag when software arms a line that is already at its active level. A single wakeup request output is the OR of all eight flags. Software clears flags through a separate write-one-to-clear register, which always reads back as zero.

A per-line protection mask controls access to each line. For a protected line, non-secure bus writes cannot change its configuration and cannot clear its flag. Non-secure reads see zeros in that line's fields. Only a secure write can change the mask. The pad pull code is driven out only while the line is armed, so the pad holds its pull setting as long as the arm bit stays set.

The register bus is a simple single-cycle port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from the current state and the request fields.

Top module: `wkp_ctrl`

## Requirements
- R1: After reset, every register (configuration, flags, protection mask) reads 0, `pull_o` is 0 and `wake_req` is 0.
- R2: The configuration register is at word address 0. It holds arm bits at [7:0], edge-sense bits at [15:8] and two-bit pull codes at [17+2i:16+2i] for line i. A secure access can write and read back every field.
- R3: An armed line with edge-sense 0 sets its flag on a 0-to-1 transition of `pin_in`. With edge-sense 1 it sets its flag on a 1-to-0 transition. The flag is visible one clock after the edge is sampled.
- R4: Transitions on an unarmed line never set its flag.
- R5: A configuration write that changes a line's arm bit from 0 to 1 sets that line's flag at the same clock edge if `pin_in` is already at the active level: high for edge-sense 0, low for edge-sense 1.
- R6: Flags at word address 1 are sticky. They clear only on reset or when 1 is written to the matching bit of the clear register at word address 2. The clear register always reads 0.
- R7: If a line's event and a clear of its flag happen in the same cycle, the flag ends up set.
- R8: `wake_req` is high exactly when at least one flag is set.
- R9: `pull_o[2i+1:2i]` carries line i's pull code while its arm bit is set, and 00 otherwise.
- R10: The protection mask is at word address 3, bits [7:0], and any access can read it. Only a secure write changes it; non-secure writes to it have no effect.
- R11: When line i's mask bit is set, a non-secure write leaves line i's arm, edge-sense and pull fields unchanged and does not clear its flag. A non-secure read returns 0 in line i's configuration and flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | Request carries the secure attribute |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 8 | Synchronized wakeup lines |
| pull_o | output | 16 | Pull code per line, two bits each |
| wake_req | output | 1 | OR of all event flags |

## Verification
A wrong flag shows up on `wake_req` in the cycle after the bad update, and on the next read of address 1. A lost or extra edge-history bit therefore reaches the ports one clock after the line moves. A corrupted arm bit or pull code appears at once on `pull_o`, because that output is driven straight from state. A protection-mask error first shows in the next non-secure read, or as a non-secure write that should not have landed and is then visible in a secure readback. The bench compares every output on every cycle against a model built from the requirements, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
    localparam int WKP_LINES  = 8;
    localparam int WKP_PULLW  = 2;
    localparam int WKP_DATAW  = 32;
    localparam int WKP_ADDRW  = 2;

    typedef enum logic [WKP_ADDRW-1:0] {
        WKP_A_CFG  = 2'd0,
        WKP_A_FLAG = 2'd1,
        WKP_A_CLR  = 2'd2,
        WKP_A_SEC  = 2'd3
    } wkp_addr_e;
endpackage

// File: rtl/wkp_edge_det.sv
module wkp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic armed,
    input  logic falling,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
        hit    = armed & (falling ? (prev_q & ~pin) : (pin & ~prev_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/wkp_rd_mux.sv
module wkp_rd_mux
    import wkp_pkg::*;
#(
    parameter int LINES = WKP_LINES,
    parameter int PULLW = WKP_PULLW,
    parameter int DATAW = WKP_DATAW,
    parameter int ADDRW = WKP_ADDRW
) (
    input  logic [ADDRW-1:0]       addr,
    input  logic                   secure,
    input  logic [LINES-1:0]       en,
    input  logic [LINES-1:0]       pol,
    input  logic [LINES-1:0]       flag,
    input  logic [LINES-1:0]       sec,
    input  logic [LINES*PULLW-1:0] pull,
    output logic [DATAW-1:0]       rdata
);
    localparam int PULL_LSB = 2 * LINES;

    logic [LINES-1:0] vis;

    always_comb begin
        vis   = secure ? {LINES{1'b1}} : ~sec;
        rdata = '0;
        case (addr)
            WKP_A_CFG: begin
                for (int i = 0; i < LINES; i++) begin
                    rdata[i]         = en[i]  & vis[i];
                    rdata[LINES + i] = pol[i] & vis[i];
                    rdata[PULL_LSB + i*PULLW +: PULLW] =
                        vis[i] ? pull[i*PULLW +: PULLW] : '0;
                end
            end
            WKP_A_FLAG: rdata[LINES-1:0] = flag & vis;
            WKP_A_SEC:  rdata[LINES-1:0] = sec;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/wkp_ctrl.sv
module wkp_ctrl
    import wkp_pkg::*;
#(
    parameter int LINES = WKP_LINES,
    parameter int PULLW = WKP_PULLW,
    parameter int DATAW = WKP_DATAW,
    parameter int ADDRW = WKP_ADDRW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic                   bus_secure,
    input  logic [ADDRW-1:0]       bus_addr,
    input  logic [DATAW-1:0]       bus_wdata,
    output logic [DATAW-1:0]       bus_rdata,
    input  logic [LINES-1:0]       pin_in,
    output logic [LINES*PULLW-1:0] pull_o,
    output logic                   wake_req
);
    localparam int POL_LSB  = LINES;
    localparam int PULL_LSB = 2 * LINES;

    typedef struct packed {
        logic [LINES-1:0]       en;
        logic [LINES-1:0]       pol;
        logic [LINES-1:0]       flag;
        logic [LINES-1:0]       sec;
        logic [LINES*PULLW-1:0] pull;
    } wkp_state_t;

    wkp_state_t       st_d, st_q;
    logic [LINES-1:0] wmask_d, arm_d, clr_hit_d, edge_hit;
    logic             cfg_wr, clr_wr, sec_wr;

    // per-line edge history and direction selection
    for (genvar g = 0; g < LINES; g++) begin : g_line
        wkp_edge_det u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[g]),
            .armed   (st_q.en[g]),
            .falling (st_q.pol[g]),
            .hit     (edge_hit[g])
        );
        assign pull_o[g*PULLW +: PULLW] =
            st_q.en[g] ? st_q.pull[g*PULLW +: PULLW] : '0;
    end

    always_comb begin
        st_d    = st_q;
        cfg_wr  = bus_valid & bus_write & (bus_addr == WKP_A_CFG);
        clr_wr  = bus_valid & bus_write & (bus_addr == WKP_A_CLR);
        sec_wr  = bus_valid & bus_write & (bus_addr == WKP_A_SEC);
        wmask_d = bus_secure ? {LINES{1'b1}} : ~st_q.sec;

        for (int i = 0; i < LINES; i++) begin
            if (cfg_wr && wmask_d[i]) begin
                st_d.en[i]  = bus_wdata[i];
                st_d.pol[i] = bus_wdata[POL_LSB + i];
                st_d.pull[i*PULLW +: PULLW] = bus_wdata[PULL_LSB + i*PULLW +: PULLW];
            end
        end

        // newly armed line already sitting at its active level
        arm_d     = st_d.en & ~st_q.en & (pin_in ^ st_d.pol);
        clr_hit_d = clr_wr ? (bus_wdata[LINES-1:0] & wmask_d) : '0;
        st_d.flag = (st_q.flag & ~clr_hit_d) | edge_hit | arm_d;

        if (sec_wr && bus_secure) st_d.sec = bus_wdata[LINES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_req = |st_q.flag;

    wkp_rd_mux #(
        .LINES (LINES),
        .PULLW (PULLW),
        .DATAW (DATAW),
        .ADDRW (ADDRW)
    ) u_rd_mux (
        .addr   (bus_addr),
        .secure (bus_secure),
        .en     (st_q.en),
        .pol    (st_q.pol),
        .flag   (st_q.flag),
        .sec    (st_q.sec),
        .pull   (st_q.pull),
        .rdata  (bus_rdata)
    );

    // checks guarding the flag and protection logic
    for (genvar a = 0; a < LINES; a++) begin : g_chk
        p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[a] |=> st_q.flag[a]);
        p_unarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.en[a] && !arm_d[a]) |=> !$rose(st_q.flag[a]));
        p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag[a]) |-> $past(clr_hit_d[a]));
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((edge_hit[a] || arm_d[a]) && clr_hit_d[a]) |=> st_q.flag[a]);
    end

    p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(|(edge_hit | arm_d)));

    p_mask_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_secure && bus_addr == WKP_A_SEC) |=> $stable(st_q.sec));
endmodule

// File: tb/wkp_ctrl_bench.sv
module wkp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [15:0] pull_o;
    logic        wake_req;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [7:0]  m_en = '0, m_pol = '0, m_flag = '0, m_sec = '0, m_prev = '0;
    logic [15:0] m_pull = '0;

    always #2 clk = ~clk;

    wkp_ctrl u_wkp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pull_o(pull_o), .wake_req(wake_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] a, logic s);
        logic [7:0]  vis;
        logic [31:0] r;
        vis = s ? 8'hFF : ~m_sec;
        r = '0;
        case (a)
            2'd0: begin
                r[7:0]  = m_en & vis;
                r[15:8] = m_pol & vis;
                for (int i = 0; i < 8; i++)
                    r[16 + 2*i +: 2] = vis[i] ? m_pull[2*i +: 2] : 2'b00;
            end
            2'd1: r[7:0] = m_flag & vis;
            2'd3: r[7:0] = m_sec;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] exp_pull();
        logic [15:0] p;
        for (int i = 0; i < 8; i++) p[2*i +: 2] = m_en[i] ? m_pull[2*i +: 2] : 2'b00;
        return p;
    endfunction

    // one bus cycle: drive at negedge, compare, advance model across posedge
    task automatic step(string tag, logic v, logic w, logic [1:0] a, logic s,
                        logic [31:0] wd, logic [7:0] pins);
        logic [7:0]  wm, ev, arm, clr, n_en, n_pol;
        logic [15:0] n_pull;
        bus_valid = v; bus_write = w; bus_addr = a; bus_secure = s;
        bus_wdata = wd; pin_in = pins;
        #1;
        if (v && !w) chk(tag, bus_rdata, exp_read(a, s));
        chk("R8", {31'b0, wake_req}, {31'b0, |m_flag});
        chk("R9", {16'b0, pull_o}, {16'b0, exp_pull()});
        wm = s ? 8'hFF : ~m_sec;
        ev = m_en & ((pins & ~m_prev & ~m_pol) | (~pins & m_prev & m_pol));
        n_en = m_en; n_pol = m_pol; n_pull = m_pull;
        if (v && w && a == 2'd0) begin
            n_en  = (m_en & ~wm) | (wd[7:0] & wm);
            n_pol = (m_pol & ~wm) | (wd[15:8] & wm);
            for (int i = 0; i < 8; i++)
                if (wm[i]) n_pull[2*i +: 2] = wd[16 + 2*i +: 2];
        end
        arm = n_en & ~m_en & (pins ^ n_pol);
        clr = (v && w && a == 2'd2) ? (wd[7:0] & wm) : 8'h00;
        @(posedge clk);
        m_flag = (m_flag & ~clr) | ev | arm;
        m_en = n_en; m_pol = n_pol; m_pull = n_pull; m_prev = pins;
        if (v && w && a == 2'd3 && s) m_sec = wd[7:0];
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cur;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        step("R1", 1, 0, 2'd0, 1, 0, 8'h00);
        step("R1", 1, 0, 2'd1, 1, 0, 8'h00);
        step("R1", 1, 0, 2'd3, 0, 0, 8'h00);
        // R2: configuration layout and readback
        step("R2", 1, 1, 2'd0, 1, 32'h0004_0201, 8'h00);
        step("R2", 1, 0, 2'd0, 1, 0, 8'h00);
        // R3: rising edge on armed line 0
        step("R3", 0, 0, 2'd0, 1, 0, 8'h01);
        step("R3", 1, 0, 2'd1, 1, 0, 8'h01);
        // R6: clear, clear register reads 0
        step("R6", 1, 1, 2'd2, 1, 32'h1, 8'h01);
        step("R6", 1, 0, 2'd2, 1, 0, 8'h01);
        step("R6", 1, 0, 2'd1, 1, 0, 8'h01);
        // R5: arm line 1 (falling) while it is low
        step("R5", 1, 1, 2'd0, 1, 32'h0004_0203, 8'h01);
        step("R5", 1, 0, 2'd1, 1, 0, 8'h01);
        // R3: falling edge on line 1 after clearing
        step("R3", 1, 1, 2'd2, 1, 32'h2, 8'h03);
        step("R3", 0, 0, 2'd0, 1, 0, 8'h01);
        step("R3", 1, 0, 2'd1, 1, 0, 8'h01);
        // R4: unarmed line 2 toggling
        step("R4", 1, 1, 2'd0, 1, 32'h0000_0001, 8'h01);
        step("R4", 1, 1, 2'd2, 1, 32'hFF, 8'h05);
        step("R4", 0, 0, 2'd0, 1, 0, 8'h01);
        step("R4", 1, 0, 2'd1, 1, 0, 8'h05);
        // R7: edge and clear in the same cycle
        step("R7", 0, 0, 2'd0, 1, 0, 8'h00);
        step("R7", 1, 1, 2'd2, 1, 32'h1, 8'h01);
        step("R7", 1, 0, 2'd1, 1, 0, 8'h01);
        // R10: mask only changes on secure writes
        step("R10", 1, 1, 2'd3, 0, 32'hFF, 8'h01);
        step("R10", 1, 0, 2'd3, 0, 0, 8'h01);
        step("R10", 1, 1, 2'd3, 1, 32'h01, 8'h01);
        step("R10", 1, 0, 2'd3, 1, 0, 8'h01);
        // R11: non-secure access to protected line 0
        step("R11", 1, 1, 2'd0, 0, 32'hFFFF_FF00, 8'h01);
        step("R11", 1, 0, 2'd0, 0, 0, 8'h01);
        step("R11", 1, 0, 2'd0, 1, 0, 8'h01);
        step("R11", 1, 1, 2'd2, 0, 32'h01, 8'h01);
        step("R11", 1, 0, 2'd1, 1, 0, 8'h01);
        step("R11", 1, 0, 2'd1, 0, 0, 8'h01);
        // random mix across all requirements
        cur = 8'h01;
        for (int k = 0; k < 4000; k++) begin
            logic [1:0]  a;
            logic        w, s, v;
            logic [31:0] wd;
            string       tg;
            if ($urandom_range(0, 3) == 0) cur = cur ^ 8'($urandom);
            v  = ($urandom_range(0, 3) != 0);
            w  = ($urandom_range(0, 2) == 0);
            s  = ($urandom_range(0, 1) == 0);
            a  = 2'($urandom);
            wd = $urandom;
            if (a == 2'd2 && $urandom_range(0, 1) == 0) wd[7:0] = 8'h00;
            case (a)
                2'd0: tg = s ? "R2" : "R11";
                2'd1: tg = s ? "R6" : "R11";
                2'd2: tg = "R6";
                default: tg = "R10";
            endcase
            step(tg, v, w, a, s, wd, cur);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule